// File: doc/BRIEF.md
# DMA Register Access Grant Gate

This block guards the DMA programming registers of a flash controller. It holds a 32-bit DMA control/status word plus three transfer parameters: a DRAM address, a flash address and a transfer length. All four are written through one register write port. Software must first obtain an access grant by writing a special command word to the control register. Until it has one, any attempt to program the transfer is refused and recorded in a sticky error flag.

Once the grant is held, software may load the address and length registers. Both addresses are trimmed to their legal, word-aligned ranges. A final write to the control register hands the word to the DMA engine that follows this block and removes the grant at the same time. If that word has its enable bit set, the engine gets a start pulse one cycle long together with the stored word. A second command word gives the grant back without starting anything.

A parameter can switch the handshake off. Every write is then accepted as though the grant were always held.

Top module: `dma_grant_gate`

The handshake is a three-state machine:
- `ST_LOCKED`: no grant is held.
- `ST_OPEN`: the grant and request flags are both set.
- `ST_FIRE`: a one-cycle launch state that drives the start pulse.

It has these transitions:
- LOCKED→OPEN on the grant command.
- OPEN→LOCKED on the release command, or on a program write with enable clear.
- OPEN→FIRE on a program write with enable set.
- FIRE→OPEN on the grant command.
- FIRE→FIRE on a back-to-back enabled program write. This is reachable only with the handshake off.
- FIRE→LOCKED otherwise.
- LOCKED→FIRE on an enabled program write. This too is reachable only with the handshake off.

## Requirements
- R1: After reset the control word, DRAM address, flash address and length all read zero, the error flag is low and the start pulse is low.
- R2: With the handshake on and no grant held, writing 0xAEED0000 to the control register at byte offset 0x80 sets bit 31 (request) and bit 30 (grant) of the control word. Bits 29..0 are left unchanged and no start pulse follows.
- R3: Writing 0xDEEA0000 to the control register clears request and grant at any time. Bits 29..0 are left unchanged and no start pulse follows.
- R4: Before a control write is classified, the current request and grant bits are OR-ed into the written value. While the grant is held, 0xAEED0000 therefore becomes 0xEEED0000 and is handled as an ordinary program write, which stores 0x2EED0000 and drops the grant.
- R5: A control write that is neither command word, made while the grant is clear, leaves every register unchanged and sets the error flag.
- R6: Writes to the DRAM address (offset 0x84), the flash address (0x88) and the length (0x8C) are dropped while the grant is clear, and each such drop sets the error flag. While the grant is held they are accepted and leave the grant unchanged.
- R7: An accepted DRAM address is stored AND 0x3FFFFFFC. An accepted flash address is stored AND 0x0FFFFFFC. An accepted length is stored as written.
- R8: A control write made while the grant is held, other than the release word, stores the merged value with bits 31 and 30 cleared. From the next cycle, request and grant read zero.
- R9: When an accepted control write has bit 0 (enable) set, `start` is high for exactly the following cycle and `start_word` then equals the stored control word. With bit 0 clear, no pulse follows.
- R10: The error flag stays high until `err_clr` is asserted. If an error is raised in the same cycle as `err_clr`, the error flag stays set.
- R11: With `GRANT_EN` = 0, every write is accepted and no command word is recognised. The control word is stored exactly as written, and the error flag never rises.
- R12: Writes to any offset other than the four registers change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| err_clr | input | 1 | Clears the sticky error flag |
| ctrl_q | output | 32 | Control/status word including request (31) and grant (30) |
| dram_addr_q | output | 32 | Stored DRAM address |
| flash_addr_q | output | 32 | Stored flash address |
| len_q | output | 32 | Stored transfer length |
| start | output | 1 | One-cycle launch pulse to the DMA engine |
| start_word | output | 32 | Control word presented with the launch pulse |
| err | output | 1 | Sticky refused-write flag |

## Verification
Two pairs of functions can coincide in a single cycle.

The first pair is the launch cycle and a new grant request. The bench writes the grant command in the exact cycle where `start` is high from the previous program write. The reference model then expects the pulse to finish normally and the grant to be held from the next cycle.

The second pair is an error being raised and `err_clr`. The bench drives a refused control write together with `err_clr`, and the model expects the flag to stay set.

A randomized phase then mixes command words, program writes and clear pulses so that both collisions recur. Both a handshake-on and a handshake-off instance are compared with the model on every clock.

// File: rtl/dgg_pkg.sv
package dgg_pkg;

    localparam int WORD_W = 32;

    // Command words recognised on the control register (after merging).
    localparam logic [WORD_W-1:0] CMD_WORD_GRANT   = 32'hAEED_0000;
    localparam logic [WORD_W-1:0] CMD_WORD_RELEASE = 32'hDEEA_0000;

    // Request and grant flag positions in the control word.
    localparam int REQ_BIT = 31;
    localparam int GNT_BIT = 30;
    localparam int EN_BIT  = 0;
    localparam logic [WORD_W-1:0] HS_MASK = (WORD_W'(1) << REQ_BIT) | (WORD_W'(1) << GNT_BIT);

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_FIRE   = 2'd2
    } gate_state_e;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_DRAM  = 3'd2,
        SEL_FLASH = 3'd3,
        SEL_LEN   = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_GRANT   = 3'd1,
        CMD_RELEASE = 3'd2,
        CMD_PROGRAM = 3'd3,
        CMD_REJECT  = 3'd4
    } ctrl_cmd_e;

endpackage

// File: rtl/dgg_decode.sv
module dgg_decode
    import dgg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h80,
    parameter logic [ADDR_W-1:0] DRAM_OFS  = 8'h84,
    parameter logic [ADDR_W-1:0] FLASH_OFS = 8'h88,
    parameter logic [ADDR_W-1:0] LEN_OFS   = 8'h8C,
    parameter bit                GRANT_EN  = 1'b1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              hs_held,
    input  logic              granted,
    output reg_sel_e          sel,
    output ctrl_cmd_e         cmd,
    output logic [WORD_W-1:0] merged,
    output logic              data_ok,
    output logic              data_rej
);

    logic is_data_reg;

    // Register select from the byte offset.
    always_comb begin
        sel = SEL_NONE;
        if (wr_addr == CTRL_OFS) begin
            sel = SEL_CTRL;
        end else if (wr_addr == DRAM_OFS) begin
            sel = SEL_DRAM;
        end else if (wr_addr == FLASH_OFS) begin
            sel = SEL_FLASH;
        end else if (wr_addr == LEN_OFS) begin
            sel = SEL_LEN;
        end
    end

    // Merge the held handshake flags into the incoming control value.
    generate
        if (GRANT_EN) begin : g_merge
            assign merged = wr_data | (hs_held ? HS_MASK : '0);
        end else begin : g_plain
            assign merged = wr_data;
        end
    endgenerate

    // Classify a control write.
    always_comb begin
        cmd = CMD_NONE;
        if (wr_en && sel == SEL_CTRL) begin
            if (GRANT_EN && merged == CMD_WORD_GRANT) begin
                cmd = CMD_GRANT;
            end else if (GRANT_EN && merged == CMD_WORD_RELEASE) begin
                cmd = CMD_RELEASE;
            end else if (granted) begin
                cmd = CMD_PROGRAM;
            end else begin
                cmd = CMD_REJECT;
            end
        end
    end

    assign is_data_reg = (sel == SEL_DRAM) || (sel == SEL_FLASH) || (sel == SEL_LEN);
    assign data_ok     = wr_en && is_data_reg && granted;
    assign data_rej    = wr_en && is_data_reg && !granted;

endmodule

// File: rtl/dgg_fsm.sv
module dgg_fsm
    import dgg_pkg::*;
#(
    parameter bit GRANT_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  ctrl_cmd_e   cmd,
    input  logic        launch_req,
    output gate_state_e state_q,
    output logic        hs_held,
    output logic        granted,
    output logic        start
);

    gate_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (cmd == CMD_GRANT) begin
                    state_d = ST_OPEN;
                end else if (cmd == CMD_PROGRAM && launch_req) begin
                    state_d = ST_FIRE;
                end
            end
            ST_OPEN: begin
                if (cmd == CMD_RELEASE) begin
                    state_d = ST_LOCKED;
                end else if (cmd == CMD_PROGRAM) begin
                    state_d = launch_req ? ST_FIRE : ST_LOCKED;
                end
            end
            ST_FIRE: begin
                if (cmd == CMD_GRANT) begin
                    state_d = ST_OPEN;
                end else if (cmd == CMD_PROGRAM && launch_req) begin
                    state_d = ST_FIRE;
                end else begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        hs_held = (state_q == ST_OPEN);
        start   = (state_q == ST_FIRE);
        granted = GRANT_EN ? hs_held : 1'b1;
    end

endmodule

// File: rtl/dgg_regs.sv
module dgg_regs
    import dgg_pkg::*;
#(
    parameter logic [WORD_W-1:0] DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [WORD_W-1:0] FLASH_MASK = 32'h0FFF_FFFC,
    parameter logic [WORD_W-1:0] LEN_MASK   = 32'hFFFF_FFFF,
    parameter bit                GRANT_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_cmd_e         cmd,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] merged,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              data_ok,
    input  logic              data_rej,
    input  logic              err_clr,
    output logic [WORD_W-1:0] ctrl_body,
    output logic [WORD_W-1:0] dram_addr_q,
    output logic [WORD_W-1:0] flash_addr_q,
    output logic [WORD_W-1:0] len_q,
    output logic              err_q
);

    localparam int NFIELD = 3;
    localparam logic [WORD_W-1:0] STORE_MASK = GRANT_EN ? ~HS_MASK : '1;

    logic err_set;

    function automatic reg_sel_e field_sel(input int idx);
        case (idx)
            0:       return SEL_DRAM;
            1:       return SEL_FLASH;
            default: return SEL_LEN;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] field_mask(input int idx);
        case (idx)
            0:       return DRAM_MASK;
            1:       return FLASH_MASK;
            default: return LEN_MASK;
        endcase
    endfunction

    // Control body: flags stripped when the handshake is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_body <= '0;
        end else if (cmd == CMD_PROGRAM) begin
            ctrl_body <= merged & STORE_MASK;
        end
    end

    // Transfer parameter registers, one per field.
    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
        localparam reg_sel_e          MY_SEL  = field_sel(gi);
        localparam logic [WORD_W-1:0] MY_MASK = field_mask(gi);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (data_ok && sel == MY_SEL) begin
                q <= wr_data & MY_MASK;
            end
        end
    end

    assign dram_addr_q  = g_field[0].q;
    assign flash_addr_q = g_field[1].q;
    assign len_q        = g_field[2].q;

    // Sticky error: a new refusal outranks a clear.
    assign err_set = (cmd == CMD_REJECT) || data_rej;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_grant_gate.sv
module dma_grant_gate
    import dgg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 8'h80,
    parameter logic [ADDR_W-1:0] DRAM_OFS   = 8'h84,
    parameter logic [ADDR_W-1:0] FLASH_OFS  = 8'h88,
    parameter logic [ADDR_W-1:0] LEN_OFS    = 8'h8C,
    parameter logic [31:0]       DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [31:0]       FLASH_MASK = 32'h0FFF_FFFC,
    parameter logic [31:0]       LEN_MASK   = 32'hFFFF_FFFF,
    parameter bit                GRANT_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              err_clr,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       dram_addr_q,
    output logic [31:0]       flash_addr_q,
    output logic [31:0]       len_q,
    output logic              start,
    output logic [31:0]       start_word,
    output logic              err
);

    reg_sel_e          sel;
    ctrl_cmd_e         cmd;
    gate_state_e       state_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] ctrl_body;
    logic              data_ok;
    logic              data_rej;
    logic              hs_held;
    logic              granted;
    logic              launch_req;

    dgg_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .DRAM_OFS (DRAM_OFS),
        .FLASH_OFS(FLASH_OFS),
        .LEN_OFS  (LEN_OFS),
        .GRANT_EN (GRANT_EN)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hs_held (hs_held),
        .granted (granted),
        .sel     (sel),
        .cmd     (cmd),
        .merged  (merged),
        .data_ok (data_ok),
        .data_rej(data_rej)
    );

    assign launch_req = merged[EN_BIT];

    dgg_fsm #(
        .GRANT_EN(GRANT_EN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .launch_req(launch_req),
        .state_q   (state_q),
        .hs_held   (hs_held),
        .granted   (granted),
        .start     (start)
    );

    dgg_regs #(
        .DRAM_MASK (DRAM_MASK),
        .FLASH_MASK(FLASH_MASK),
        .LEN_MASK  (LEN_MASK),
        .GRANT_EN  (GRANT_EN)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .sel         (sel),
        .merged      (merged),
        .wr_data     (wr_data),
        .data_ok     (data_ok),
        .data_rej    (data_rej),
        .err_clr     (err_clr),
        .ctrl_body   (ctrl_body),
        .dram_addr_q (dram_addr_q),
        .flash_addr_q(flash_addr_q),
        .len_q       (len_q),
        .err_q       (err)
    );

    generate
        if (GRANT_EN) begin : g_hs_view
            assign ctrl_q = ctrl_body | (hs_held ? HS_MASK : '0);
        end else begin : g_raw_view
            assign ctrl_q = ctrl_body;
        end
    endgenerate

    assign start_word = ctrl_body;

endmodule

// File: rtl/dgg_checker.sv
module dgg_checker #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 8'h80,
    parameter logic [ADDR_W-1:0] DRAM_OFS   = 8'h84,
    parameter logic [31:0]       DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [31:0]       FLASH_MASK = 32'h0FFF_FFFC,
    parameter bit                GRANT_EN   = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              err_clr,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       dram_addr_q,
    input logic [31:0]       flash_addr_q,
    input logic              start,
    input logic              err
);

    AST_HS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (GRANT_EN != 0) |-> (ctrl_q[31] == ctrl_q[30])); // R2

    AST_LOCKED_DRAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (GRANT_EN != 0 && !ctrl_q[30] && wr_en && wr_addr == DRAM_OFS) |=> $stable(dram_addr_q)); // R6

    AST_DRAM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_addr_q & ~DRAM_MASK) == 32'h0); // R7

    AST_FLASH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_addr_q & ~FLASH_MASK) == 32'h0); // R7

    AST_LAUNCH_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (GRANT_EN != 0 && start) |-> !ctrl_q[30]); // R8

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_en && wr_addr == CTRL_OFS && wr_data[0])); // R9

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(wr_en && wr_addr == CTRL_OFS)) |=> !start); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R10

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !wr_en) |=> !err); // R10

    AST_OPEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (GRANT_EN == 0) |-> !err); // R11

endmodule

bind dma_grant_gate dgg_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_OFS  (CTRL_OFS),
    .DRAM_OFS  (DRAM_OFS),
    .DRAM_MASK (DRAM_MASK),
    .FLASH_MASK(FLASH_MASK),
    .GRANT_EN  (GRANT_EN)
) u_dgg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .err_clr     (err_clr),
    .ctrl_q      (ctrl_q),
    .dram_addr_q (dram_addr_q),
    .flash_addr_q(flash_addr_q),
    .start       (start),
    .err         (err)
);

// File: tb/test_dma_grant_gate.sv
module test_dma_grant_gate;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        err_clr;

    logic [31:0] o_ctrl  [2];
    logic [31:0] o_dram  [2];
    logic [31:0] o_flash [2];
    logic [31:0] o_len   [2];
    logic [31:0] o_sword [2];
    logic        o_start [2];
    logic        o_err   [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_grant_gate #(.GRANT_EN(1'b1)) i_dma_grant_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_clr(err_clr), .ctrl_q(o_ctrl[0]),
        .dram_addr_q(o_dram[0]), .flash_addr_q(o_flash[0]), .len_q(o_len[0]),
        .start(o_start[0]), .start_word(o_sword[0]), .err(o_err[0])
    );

    dma_grant_gate #(.GRANT_EN(1'b0)) i_dma_grant_gate_open (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_clr(err_clr), .ctrl_q(o_ctrl[1]),
        .dram_addr_q(o_dram[1]), .flash_addr_q(o_flash[1]), .len_q(o_len[1]),
        .start(o_start[1]), .start_word(o_sword[1]), .err(o_err[1])
    );

    // Reference model state, one set per instance (0: handshake on, 1: off).
    bit          m_hs    [2];
    logic [31:0] m_ctrl  [2];
    logic [31:0] m_dram  [2];
    logic [31:0] m_flash [2];
    logic [31:0] m_len   [2];
    bit          m_err   [2];
    bit          m_start [2];

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_hs[k] = 0; m_ctrl[k] = 0; m_dram[k] = 0; m_flash[k] = 0;
            m_len[k] = 0; m_err[k] = 0; m_start[k] = 0;
        end
    endtask

    task automatic model_step();
        for (int k = 0; k < 2; k++) begin
            bit          hs_on = (k == 0);
            bit          raise = 0;
            bit          fire  = 0;
            logic [31:0] v;
            if (wr_en && wr_addr == 8'h80) begin
                v = (hs_on && m_hs[k]) ? (wr_data | 32'hC000_0000) : wr_data;
                if (hs_on && v == 32'hAEED_0000) begin
                    m_hs[k] = 1;
                end else if (hs_on && v == 32'hDEEA_0000) begin
                    m_hs[k] = 0;
                end else if (hs_on && !m_hs[k]) begin
                    raise = 1;
                end else begin
                    m_ctrl[k] = hs_on ? (v & 32'h3FFF_FFFF) : v;
                    m_hs[k]   = 0;
                    fire      = v[0];
                end
            end else if (wr_en && (wr_addr == 8'h84 || wr_addr == 8'h88 || wr_addr == 8'h8C)) begin
                if (hs_on && !m_hs[k]) begin
                    raise = 1;
                end else if (wr_addr == 8'h84) begin
                    m_dram[k] = wr_data & 32'h3FFF_FFFC;
                end else if (wr_addr == 8'h88) begin
                    m_flash[k] = wr_data & 32'h0FFF_FFFC;
                end else begin
                    m_len[k] = wr_data;
                end
            end
            if (raise) m_err[k] = 1;
            else if (err_clr) m_err[k] = 0;
            m_start[k] = fire;
        end
    endtask

    task automatic check(string tag, string what, int k, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d %s: actual %h expected %h", tag, k, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 2; k++) begin
            logic [31:0] exp_ctrl = (k == 0 && m_hs[k]) ? (m_ctrl[k] | 32'hC000_0000) : m_ctrl[k];
            check(cur_tag, "ctrl", k, o_ctrl[k], exp_ctrl);
            check(cur_tag, "dram", k, o_dram[k], m_dram[k]);
            check(cur_tag, "flash", k, o_flash[k], m_flash[k]);
            check(cur_tag, "len", k, o_len[k], m_len[k]);
            check(cur_tag, "start", k, {31'b0, o_start[k]}, {31'b0, m_start[k]});
            check(cur_tag, "err", k, {31'b0, o_err[k]}, {31'b0, m_err[k]});
            if (m_start[k]) check(cur_tag, "start_word", k, o_sword[k], m_ctrl[k]);
        end
    endtask

    // One clock: judge the previous result, then apply new stimulus.
    task automatic cyc(bit en, logic [7:0] addr, logic [31:0] data, bit clr, string tag);
        @(negedge clk);
        compare_all();
        wr_en = en; wr_addr = addr; wr_data = data; err_clr = clr;
        cur_tag = tag;
        model_step();
    endtask

    task automatic idle(string tag);
        cyc(1'b0, 8'h00, 32'h0, 1'b0, tag);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; err_clr = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";

        idle("R1");                                     // reset state judged here
        cyc(1, 8'h80, 32'h0000_0101, 0, "R5");          // refused program write
        idle("R5");
        cyc(0, 8'h00, 32'h0, 1, "R10");                 // clear error
        cyc(1, 8'h80, 32'h0000_0003, 1, "R10");         // refusal and clear together
        idle("R10");
        cyc(1, 8'h84, 32'h1234_5678, 1, "R6");          // dropped while locked
        cyc(0, 8'h00, 32'h0, 1, "R6");
        cyc(1, 8'h80, 32'hAEED_0000, 0, "R2");          // obtain grant
        cyc(1, 8'h84, 32'hFFFF_FFFF, 0, "R7");
        cyc(1, 8'h88, 32'hFFFF_FFFF, 0, "R7");
        cyc(1, 8'h8C, 32'h1234_5677, 0, "R6");
        cyc(1, 8'h80, 32'hAEED_0000, 0, "R4");          // merged to a program write
        idle("R4");
        cyc(1, 8'h80, 32'hAEED_0000, 0, "R2");
        cyc(1, 8'h80, 32'hDEEA_0000, 0, "R3");          // give the grant back
        cyc(1, 8'h88, 32'h0000_1000, 0, "R6");          // dropped again
        cyc(0, 8'h00, 32'h0, 1, "R10");
        cyc(1, 8'h80, 32'hAEED_0000, 0, "R2");
        cyc(1, 8'h90, 32'hFFFF_FFFF, 0, "R12");         // unmapped offsets
        cyc(1, 8'h7C, 32'hFFFF_FFFF, 0, "R12");
        cyc(1, 8'h80, 32'h0000_0C05, 0, "R9");          // launch
        cyc(1, 8'h80, 32'hAEED_0000, 0, "R8");          // grant during the pulse
        idle("R8");
        cyc(1, 8'h80, 32'h0000_0A00, 0, "R8");          // store without launch
        idle("R9");
        cyc(1, 8'h80, 32'hAEED_0001, 0, "R11");         // plain word when handshake off
        cyc(1, 8'h80, 32'h0000_0001, 0, "R11");
        cyc(1, 8'h80, 32'h0000_0003, 0, "R11");
        idle("R11");

        // Mixed traffic so grant, launch, refusal and clear collide.
        for (int i = 0; i < 400; i++) begin
            int          pick = $urandom_range(0, 9);
            logic [7:0]  a;
            logic [31:0] d = $urandom();
            case (pick)
                0, 1:    begin a = 8'h80; d = 32'hAEED_0000; end
                2:       begin a = 8'h80; d = 32'hDEEA_0000; end
                3:       a = 8'h80;
                4:       a = 8'h84;
                5:       a = 8'h88;
                6:       a = 8'h8C;
                7:       a = 8'h94;
                default: a = 8'h80;
            endcase
            cyc(($urandom_range(0, 3) != 0), a, d, ($urandom_range(0, 5) == 0), "R8 mixed");
        end
        idle("R8 mixed");
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule